// File: doc/BRIEF.md
# Variable Range Register Encoder

This block sits beside the memory-type range registers of a processor core. It translates between a requested memory region and the two words of a variable range register pair. A region is given as a base page frame, a length in pages and an eight-bit memory type. The encode path checks that the region is legal. It then returns a base word that carries the type, a mask word that carries a valid bit, an error code, and a flag that says whether the new words differ from the stored pair in the bits that matter.

The decode path takes a stored pair and returns the base page frame, the length in pages and the type. It also repairs a mask whose high bits were left clear. A third path picks a register slot for a new region. All three paths accept a request in any cycle and answer one clock later with a one-cycle done strobe. Pages are 4 KiB. The upper word of each pair holds the address bits above bit 31, limited to the physical address width `PA_WIDTH`. With the default of 36, a frame number is 24 bits wide and the upper word is 4 bits wide.

Top module: `vrange_codec`

## Requirements
- R1: Each of `enc_valid`, `dec_valid` and `srch_valid` sampled high at a clock edge makes the matching done output high for exactly the following cycle, with its results valid in that cycle. A done output is low in any cycle that follows an edge where its request was low, and all done outputs are low after reset.
- R2: An encode with a length of zero reports error 0 (none). All four output words are zero, which means the slot is disabled.
- R3: A legal encode gives base low word = {frame[19:0], 4'b0000, type[7:0]} and base high word = frame[PFN_W-1:20].
- R4: A legal encode uses neg = (0 − length) mod 2^PFN_W. It gives mask low word = {neg[19:0], 1'b1, 11'b0}, where bit 11 is the valid bit, and mask high word = neg[PFN_W-1:20].
- R5: Take first = base frame and last = base + length − 1. The region is legal only if first and last agree above some bit position k, and below k first is all zeros and last is all ones. Otherwise the error is 1 (misaligned). Any error forces all four output words to zero.
- R6: With `erratum_en` high, a base frame whose low 10 bits (4 MiB) are not all zero gives error 3. This check takes priority over R7 and R5.
- R7: With `erratum_en` high, a region of type 1 or type 6 is rejected with error 2 when base + length ≥ 0x70000 and base ≤ 0x7003F. This check takes priority over R5.
- R8: `enc_changed` is high when the produced words differ from the stored `cur_*` words in any of these bits:
  - base low bits other than 11:8;
  - base high bits;
  - mask low bits 31:11;
  - mask high bits.
- R9: A decode of a mask low word with bit 11 clear returns frame 0, length 0, type 0 and no repair.
- R10: A decode with bit 11 set returns the frame {base_hi, base_lo[31:12]} and the type base_lo[7:0]. The length is 2^PFN_W minus the repaired page mask, where the raw page mask is {mask_hi, mask_lo[31:12]}.
- R11: Repair forces to one every bit of the raw page mask from its highest set bit up to bit PFN_W−1. `dec_repaired` is high exactly when this changed the mask. A zero mask is left unchanged.
- R12: A slot search whose `srch_repl` is below `NUM_SLOTS` returns that index with error 0.
- R13: Otherwise the search returns the lowest slot whose `slot_used` bit is clear, with error 0. If every slot is used, it returns index 0 with error 4 (no space).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid | input | 1 | Encode request |
| enc_base_pfn | input | PFN_W | Region base page frame |
| enc_size_pfn | input | PFN_W | Region length in pages |
| enc_type | input | 8 | Memory type |
| erratum_en | input | 1 | Enable the extra alignment and window checks |
| cur_base_lo | input | 32 | Stored base low word |
| cur_base_hi | input | HI_W | Stored base high word |
| cur_mask_lo | input | 32 | Stored mask low word |
| cur_mask_hi | input | HI_W | Stored mask high word |
| enc_done | output | 1 | Encode result strobe |
| enc_err | output | 3 | Encode error code |
| enc_base_lo | output | 32 | New base low word |
| enc_base_hi | output | HI_W | New base high word |
| enc_mask_lo | output | 32 | New mask low word |
| enc_mask_hi | output | HI_W | New mask high word |
| enc_changed | output | 1 | New words differ from stored ones |
| dec_valid | input | 1 | Decode request |
| dec_base_lo | input | 32 | Base low word to decode |
| dec_base_hi | input | HI_W | Base high word to decode |
| dec_mask_lo | input | 32 | Mask low word to decode |
| dec_mask_hi | input | HI_W | Mask high word to decode |
| dec_done | output | 1 | Decode result strobe |
| dec_base_pfn | output | PFN_W | Decoded base frame |
| dec_size_pfn | output | PFN_W+1 | Decoded length in pages |
| dec_type | output | 8 | Decoded type |
| dec_repaired | output | 1 | Mask needed repair |
| srch_valid | input | 1 | Slot search request |
| srch_repl | input | IDX_W+1 | Requested replacement index (out of range means none) |
| slot_used | input | NUM_SLOTS | Bit i high when slot i holds a region |
| srch_done | output | 1 | Search result strobe |
| srch_idx | output | IDX_W | Chosen slot |
| srch_err | output | 3 | Search error code |

## Verification
Every result register is loaded at the edge that samples its request. All encode, decode and search outputs are therefore due exactly one edge after the request. The bench drives inputs on the falling edge. At each following falling edge it compares every done strobe against its model, and it compares the payload only in the cycles where the model expects a strobe. The model computes its expected values from the request at drive time, using shift loops and integer arithmetic.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

  typedef enum logic [2:0] {
    VRC_OK        = 3'd0,
    VRC_MISALIGN  = 3'd1,
    VRC_WINDOW    = 3'd2,
    VRC_ERR_ALIGN = 3'd3,
    VRC_NO_SPACE  = 3'd4
  } vrc_err_e;

  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int LO_PFN_W   = WORD_W - PAGE_SHIFT;
  localparam int VALID_BIT  = 11;
  localparam int TYPE_W     = 8;

  localparam logic [TYPE_W-1:0] TYPE_WCOMB = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_WBACK = 8'd6;

  localparam logic [WORD_W-1:0] BASE_CMP_MASK = 32'hFFFF_F0FF;
  localparam logic [WORD_W-1:0] MASK_CMP_MASK = 32'hFFFF_F800;

endpackage

// File: rtl/vrc_align_check.sv
module vrc_align_check
  import vrc_pkg::*;
#(
  parameter int PFN_W      = 24,
  parameter int ALIGN_BITS = 10,
  parameter logic [PFN_W:0] WIN_LO = 'h70000,
  parameter logic [PFN_W:0] WIN_HI = 'h7003F
) (
  input  logic [PFN_W-1:0]  base_pfn,
  input  logic [PFN_W-1:0]  size_pfn,
  input  logic [TYPE_W-1:0] mtype,
  input  logic              erratum_en,
  output vrc_err_e          err
);

  logic [PFN_W-1:0] size_m1;
  logic             is_pow2;
  logic             base_on_size;
  logic [PFN_W:0]   end_excl;
  logic             touches_win;
  logic             risky_type;
  logic             coarse_miss;

  always_comb begin
    size_m1      = size_pfn - 1'b1;
    is_pow2      = (size_pfn & size_m1) == '0;
    base_on_size = (base_pfn & size_m1) == '0;
    end_excl     = {1'b0, base_pfn} + {1'b0, size_pfn};
    touches_win  = (end_excl >= WIN_LO) && ({1'b0, base_pfn} <= WIN_HI);
    risky_type   = (mtype == TYPE_WCOMB) || (mtype == TYPE_WBACK);
    coarse_miss  = |base_pfn[ALIGN_BITS-1:0];

    if (size_pfn == '0) begin
      err = VRC_OK;
    end else if (erratum_en && coarse_miss) begin
      err = VRC_ERR_ALIGN;
    end else if (erratum_en && touches_win && risky_type) begin
      err = VRC_WINDOW;
    end else if (!(is_pow2 && base_on_size)) begin
      err = VRC_MISALIGN;
    end else begin
      err = VRC_OK;
    end
  end

endmodule

// File: rtl/vrc_mask_repair.sv
module vrc_mask_repair #(
  parameter int PFN_W = 24
) (
  input  logic [PFN_W-1:0] raw,
  output logic [PFN_W-1:0] fixed,
  output logic             repaired
);

  logic             nonzero;
  logic [PFN_W-1:0] any_above;

  assign nonzero = |raw;

  for (genvar i = 0; i < PFN_W; i++) begin : g_bit
    if (i == PFN_W - 1) begin : g_top
      assign any_above[i] = 1'b0;
    end else begin : g_low
      assign any_above[i] = |raw[PFN_W-1:i+1];
    end
    assign fixed[i] = raw[i] | (nonzero & ~any_above[i]);
  end

  assign repaired = (fixed != raw);

endmodule

// File: rtl/vrc_slot_pick.sv
module vrc_slot_pick
  import vrc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_SLOTS-1:0] used,
  input  logic [IDX_W:0]       repl,
  output logic [IDX_W-1:0]     idx,
  output vrc_err_e             err
);

  localparam logic [IDX_W:0] SLOT_LIMIT = (IDX_W + 1)'(NUM_SLOTS);

  logic             found;
  logic [IDX_W-1:0] lowest;

  always_comb begin
    found  = 1'b0;
    lowest = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found  = 1'b1;
        lowest = IDX_W'(i);
      end
    end

    if (repl < SLOT_LIMIT) begin
      idx = repl[IDX_W-1:0];
      err = VRC_OK;
    end else if (found) begin
      idx = lowest;
      err = VRC_OK;
    end else begin
      idx = '0;
      err = VRC_NO_SPACE;
    end
  end

endmodule

// File: rtl/vrc_change_cmp.sv
module vrc_change_cmp
  import vrc_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic [WORD_W-1:0] new_base_lo,
  input  logic [HI_W-1:0]   new_base_hi,
  input  logic [WORD_W-1:0] new_mask_lo,
  input  logic [HI_W-1:0]   new_mask_hi,
  input  logic [WORD_W-1:0] old_base_lo,
  input  logic [HI_W-1:0]   old_base_hi,
  input  logic [WORD_W-1:0] old_mask_lo,
  input  logic [HI_W-1:0]   old_mask_hi,
  output logic              differs
);

  logic base_diff;
  logic mask_diff;

  always_comb begin
    base_diff = (((new_base_lo ^ old_base_lo) & BASE_CMP_MASK) != '0) ||
                (new_base_hi != old_base_hi);
    mask_diff = (((new_mask_lo ^ old_mask_lo) & MASK_CMP_MASK) != '0) ||
                (new_mask_hi != old_mask_hi);
    differs   = base_diff || mask_diff;
  end

endmodule

// File: rtl/vrange_codec.sv
module vrange_codec
  import vrc_pkg::*;
#(
  parameter int PA_WIDTH           = 36,
  parameter int NUM_SLOTS          = 8,
  parameter int ERRATUM_ALIGN_BITS = 10,
  parameter int WIN_FIRST          = 'h70000,
  parameter int WIN_LAST           = 'h7003F,
  localparam int PFN_W = PA_WIDTH - PAGE_SHIFT,
  localparam int HI_W  = PA_WIDTH - WORD_W,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_valid,
  input  logic [PFN_W-1:0]     enc_base_pfn,
  input  logic [PFN_W-1:0]     enc_size_pfn,
  input  logic [7:0]           enc_type,
  input  logic                 erratum_en,
  input  logic [31:0]          cur_base_lo,
  input  logic [HI_W-1:0]      cur_base_hi,
  input  logic [31:0]          cur_mask_lo,
  input  logic [HI_W-1:0]      cur_mask_hi,
  output logic                 enc_done,
  output logic [2:0]           enc_err,
  output logic [31:0]          enc_base_lo,
  output logic [HI_W-1:0]      enc_base_hi,
  output logic [31:0]          enc_mask_lo,
  output logic [HI_W-1:0]      enc_mask_hi,
  output logic                 enc_changed,
  input  logic                 dec_valid,
  input  logic [31:0]          dec_base_lo,
  input  logic [HI_W-1:0]      dec_base_hi,
  input  logic [31:0]          dec_mask_lo,
  input  logic [HI_W-1:0]      dec_mask_hi,
  output logic                 dec_done,
  output logic [PFN_W-1:0]     dec_base_pfn,
  output logic [PFN_W:0]       dec_size_pfn,
  output logic [7:0]           dec_type,
  output logic                 dec_repaired,
  input  logic                 srch_valid,
  input  logic [IDX_W:0]       srch_repl,
  input  logic [NUM_SLOTS-1:0] slot_used,
  output logic                 srch_done,
  output logic [IDX_W-1:0]     srch_idx,
  output logic [2:0]           srch_err
);

  localparam logic [PFN_W:0] WIN_LO_V = (PFN_W + 1)'(WIN_FIRST);
  localparam logic [PFN_W:0] WIN_HI_V = (PFN_W + 1)'(WIN_LAST);
  localparam logic [PFN_W:0] SIZE_SPAN = {1'b1, {PFN_W{1'b0}}};

  // ---------------- encode path ----------------
  vrc_err_e          chk_err;
  logic              enc_ok;
  logic [PFN_W-1:0]  neg_size;
  logic [WORD_W-1:0] w_base_lo;
  logic [HI_W-1:0]   w_base_hi;
  logic [WORD_W-1:0] w_mask_lo;
  logic [HI_W-1:0]   w_mask_hi;
  logic              w_changed;

  vrc_align_check #(
    .PFN_W      (PFN_W),
    .ALIGN_BITS (ERRATUM_ALIGN_BITS),
    .WIN_LO     (WIN_LO_V),
    .WIN_HI     (WIN_HI_V)
  ) u_align (
    .base_pfn   (enc_base_pfn),
    .size_pfn   (enc_size_pfn),
    .mtype      (enc_type),
    .erratum_en (erratum_en),
    .err        (chk_err)
  );

  always_comb begin
    neg_size = '0 - enc_size_pfn;
    enc_ok   = (enc_size_pfn != '0) && (chk_err == VRC_OK);
    if (enc_ok) begin
      w_base_lo = {enc_base_pfn[LO_PFN_W-1:0], 4'b0000, enc_type};
      w_base_hi = enc_base_pfn[PFN_W-1:LO_PFN_W];
      w_mask_lo = {neg_size[LO_PFN_W-1:0], 1'b1, 11'b0};
      w_mask_hi = neg_size[PFN_W-1:LO_PFN_W];
    end else begin
      w_base_lo = '0;
      w_base_hi = '0;
      w_mask_lo = '0;
      w_mask_hi = '0;
    end
  end

  vrc_change_cmp #(
    .HI_W (HI_W)
  ) u_cmp (
    .new_base_lo (w_base_lo),
    .new_base_hi (w_base_hi),
    .new_mask_lo (w_mask_lo),
    .new_mask_hi (w_mask_hi),
    .old_base_lo (cur_base_lo),
    .old_base_hi (cur_base_hi),
    .old_mask_lo (cur_mask_lo),
    .old_mask_hi (cur_mask_hi),
    .differs     (w_changed)
  );

  // ---------------- decode path ----------------
  logic [PFN_W-1:0] raw_mask;
  logic [PFN_W-1:0] fixed_mask;
  logic             raw_repaired;
  logic             slot_on;
  logic [PFN_W-1:0] d_base_pfn;
  logic [PFN_W:0]   d_size_pfn;
  logic [7:0]       d_type;
  logic             d_repaired;

  assign raw_mask = {dec_mask_hi, dec_mask_lo[WORD_W-1:PAGE_SHIFT]};
  assign slot_on  = dec_mask_lo[VALID_BIT];

  vrc_mask_repair #(
    .PFN_W (PFN_W)
  ) u_repair (
    .raw      (raw_mask),
    .fixed    (fixed_mask),
    .repaired (raw_repaired)
  );

  always_comb begin
    if (slot_on) begin
      d_base_pfn = {dec_base_hi, dec_base_lo[WORD_W-1:PAGE_SHIFT]};
      d_size_pfn = SIZE_SPAN - {1'b0, fixed_mask};
      d_type     = dec_base_lo[TYPE_W-1:0];
      d_repaired = raw_repaired;
    end else begin
      d_base_pfn = '0;
      d_size_pfn = '0;
      d_type     = '0;
      d_repaired = 1'b0;
    end
  end

  // ---------------- slot search path ----------------
  logic [IDX_W-1:0] s_idx;
  vrc_err_e         s_err;

  vrc_slot_pick #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_pick (
    .used (slot_used),
    .repl (srch_repl),
    .idx  (s_idx),
    .err  (s_err)
  );

  // ---------------- result registers ----------------
  vrc_err_e enc_err_q;
  vrc_err_e srch_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_done  <= 1'b0;
      dec_done  <= 1'b0;
      srch_done <= 1'b0;
    end else begin
      enc_done  <= enc_valid;
      dec_done  <= dec_valid;
      srch_done <= srch_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_err_q   <= VRC_OK;
      enc_base_lo <= '0;
      enc_base_hi <= '0;
      enc_mask_lo <= '0;
      enc_mask_hi <= '0;
      enc_changed <= 1'b0;
    end else if (enc_valid) begin
      enc_err_q   <= chk_err;
      enc_base_lo <= w_base_lo;
      enc_base_hi <= w_base_hi;
      enc_mask_lo <= w_mask_lo;
      enc_mask_hi <= w_mask_hi;
      enc_changed <= w_changed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_base_pfn <= '0;
      dec_size_pfn <= '0;
      dec_type     <= '0;
      dec_repaired <= 1'b0;
    end else if (dec_valid) begin
      dec_base_pfn <= d_base_pfn;
      dec_size_pfn <= d_size_pfn;
      dec_type     <= d_type;
      dec_repaired <= d_repaired;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_idx   <= '0;
      srch_err_q <= VRC_OK;
    end else if (srch_valid) begin
      srch_idx   <= s_idx;
      srch_err_q <= s_err;
    end
  end

  assign enc_err  = enc_err_q;
  assign srch_err = srch_err_q;

endmodule

// File: rtl/vrange_codec_chk.sv
module vrange_codec_chk #(
  parameter int PA_WIDTH   = 36,
  parameter int NUM_SLOTS  = 8,
  parameter int ALIGN_BITS = 10,
  localparam int PFN_W = PA_WIDTH - 12,
  localparam int HI_W  = PA_WIDTH - 32,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enc_valid,
  input logic [PFN_W-1:0]     enc_base_pfn,
  input logic [PFN_W-1:0]     enc_size_pfn,
  input logic                 erratum_en,
  input logic [31:0]          cur_base_lo,
  input logic [HI_W-1:0]      cur_base_hi,
  input logic [31:0]          cur_mask_lo,
  input logic [HI_W-1:0]      cur_mask_hi,
  input logic                 enc_done,
  input logic [2:0]           enc_err,
  input logic [31:0]          enc_base_lo,
  input logic [HI_W-1:0]      enc_base_hi,
  input logic [31:0]          enc_mask_lo,
  input logic [HI_W-1:0]      enc_mask_hi,
  input logic                 enc_changed,
  input logic                 dec_valid,
  input logic [31:0]          dec_mask_lo,
  input logic [HI_W-1:0]      dec_mask_hi,
  input logic                 dec_done,
  input logic [PFN_W-1:0]     dec_base_pfn,
  input logic [PFN_W:0]       dec_size_pfn,
  input logic [7:0]           dec_type,
  input logic                 dec_repaired,
  input logic                 srch_valid,
  input logic [IDX_W:0]       srch_repl,
  input logic [NUM_SLOTS-1:0] slot_used,
  input logic                 srch_done,
  input logic [IDX_W-1:0]     srch_idx,
  input logic [2:0]           srch_err
);

  localparam logic [IDX_W:0] SLOT_LIMIT = (IDX_W + 1)'(NUM_SLOTS);

  logic [PFN_W-1:0] raw_mask;
  assign raw_mask = {dec_mask_hi, dec_mask_lo[31:12]};

  // R1: strobes follow their requests by one edge
  assert_enc_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> enc_done);
  assert_enc_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |=> !enc_done);
  assert_dec_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_done);
  assert_srch_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |=> srch_done);

  assert_disable_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_size_pfn == '0) |=>
      (enc_err == 3'd0 && enc_base_lo == '0 && enc_base_hi == '0 &&
       enc_mask_lo == '0 && enc_mask_hi == '0));

  assert_misalign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && !erratum_en && enc_size_pfn != '0 &&
     (enc_size_pfn & (enc_size_pfn - 1'b1)) != '0) |=>
      (enc_err == 3'd1 && enc_mask_lo == '0));

  assert_coarse_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && erratum_en && enc_size_pfn != '0 &&
     enc_base_pfn[ALIGN_BITS-1:0] != '0) |=> (enc_err == 3'd3));

  assert_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_size_pfn == '0 && cur_base_lo[31:12] == '0 &&
     cur_base_lo[7:0] == '0 && cur_base_hi == '0 &&
     cur_mask_lo[31:11] == '0 && cur_mask_hi == '0) |=> !enc_changed);

  assert_free_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_mask_lo[11]) |=>
      (dec_base_pfn == '0 && dec_size_pfn == '0 && dec_type == '0 && !dec_repaired));

  assert_repair_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_mask_lo[11] && raw_mask != '0 && !raw_mask[PFN_W-1]) |=>
      dec_repaired);

  assert_replace_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_repl < SLOT_LIMIT) |=>
      (srch_err == 3'd0 && {1'b0, srch_idx} == $past(srch_repl)));

  assert_lowest_free_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_err == 3'd0 && $past(srch_repl) >= SLOT_LIMIT) |->
      !(($past(slot_used) >> srch_idx) & 1'b1));

endmodule

bind vrange_codec vrange_codec_chk #(
  .PA_WIDTH   (PA_WIDTH),
  .NUM_SLOTS  (NUM_SLOTS),
  .ALIGN_BITS (ERRATUM_ALIGN_BITS)
) u_chk (.*);

// File: tb/vrange_codec_test.sv
`timescale 1ns/1ps
module vrange_codec_test;

  localparam int PFN_W = 24;
  localparam int HI_W  = 4;
  localparam int NSLOT = 8;
  localparam int IDX_W = 3;
  localparam int NCYC  = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             enc_valid = 1'b0;
  logic [PFN_W-1:0] enc_base_pfn = '0, enc_size_pfn = '0;
  logic [7:0]       enc_type = '0;
  logic             erratum_en = 1'b0;
  logic [31:0]      cur_base_lo = '0, cur_mask_lo = '0;
  logic [HI_W-1:0]  cur_base_hi = '0, cur_mask_hi = '0;
  logic             enc_done, enc_changed;
  logic [2:0]       enc_err;
  logic [31:0]      enc_base_lo, enc_mask_lo;
  logic [HI_W-1:0]  enc_base_hi, enc_mask_hi;
  logic             dec_valid = 1'b0;
  logic [31:0]      dec_base_lo = '0, dec_mask_lo = '0;
  logic [HI_W-1:0]  dec_base_hi = '0, dec_mask_hi = '0;
  logic             dec_done, dec_repaired;
  logic [PFN_W-1:0] dec_base_pfn;
  logic [PFN_W:0]   dec_size_pfn;
  logic [7:0]       dec_type;
  logic             srch_valid = 1'b0;
  logic [IDX_W:0]   srch_repl = '0;
  logic [NSLOT-1:0] slot_used = '0;
  logic             srch_done;
  logic [IDX_W-1:0] srch_idx;
  logic [2:0]       srch_err;

  vrange_codec uut (.*);

  int checks = 0;
  int errors = 0;

  bit     x_enc, x_dec, x_srch;
  int     x_err, x_serr;
  longint x_blo, x_bhi, x_mlo, x_mhi, x_sz;
  bit     x_chg, x_rep;
  longint x_dbase, x_dsize, x_dtype, x_sidx;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_enc(input longint b, input longint s, input longint t, input bit e,
                           output int err, output longint blo, output longint bhi,
                           output longint mlo, output longint mhi);
    longint lb, last, neg;
    err = 0; blo = 0; bhi = 0; mlo = 0; mhi = 0;
    if (s == 0) return;
    if (e && (b & 'h3FF) != 0) err = 3;
    else if (e && !((b + s) < 'h70000 || b > 'h7003F) && (t == 1 || t == 6)) err = 2;
    else begin
      lb = b; last = b + s - 1;
      while (((lb & 1) == 0) && ((last & 1) == 1)) begin
        lb = lb >> 1; last = last >> 1;
      end
      if (lb != last) err = 1;
    end
    if (err != 0) return;
    neg = ('h1000000 - s) & 'hFFFFFF;
    blo = ((b & 'hFFFFF) << 12) | t;
    bhi = b >> 20;
    mlo = ((neg & 'hFFFFF) << 12) | 'h800;
    mhi = neg >> 20;
  endtask

  // cur_mode: 0 random, 1 same words with ignored bits flipped, 2 one significant bit flipped
  task automatic set_enc(input longint b, input longint s, input longint t, input bit e, input int cur_mode);
    longint cbl, cbh, cml, cmh;
    enc_valid = 1'b1;
    enc_base_pfn = b[PFN_W-1:0]; enc_size_pfn = s[PFN_W-1:0];
    enc_type = t[7:0]; erratum_en = e;
    model_enc(b, s, t, e, x_err, x_blo, x_bhi, x_mlo, x_mhi);
    x_sz = s;
    if (cur_mode == 1) begin
      cbl = x_blo ^ 'hF00; cbh = x_bhi; cml = x_mlo ^ 'h7FF; cmh = x_mhi;
    end else if (cur_mode == 2) begin
      cbl = x_blo ^ 'h1000; cbh = x_bhi; cml = x_mlo; cmh = x_mhi;
    end else begin
      cbl = $urandom; cbh = $urandom % 16; cml = $urandom; cmh = $urandom % 16;
    end
    cur_base_lo = cbl[31:0]; cur_base_hi = cbh[HI_W-1:0];
    cur_mask_lo = cml[31:0]; cur_mask_hi = cmh[HI_W-1:0];
    x_chg = (((x_blo ^ cbl) & 'hFFFFF0FF) != 0) || (x_bhi != cbh) ||
            (((x_mlo ^ cml) & 'hFFFFF800) != 0) || (x_mhi != cmh);
    x_enc = 1'b1;
  endtask

  task automatic set_dec(input longint blo, input longint bhi, input longint raw, input bit on);
    longint tmp, fixed;
    int h;
    dec_valid = 1'b1;
    dec_base_lo = blo[31:0]; dec_base_hi = bhi[HI_W-1:0];
    tmp = ((raw & 'hFFFFF) << 12) | (on ? 'h800 : 0) | ($urandom & 'h7FF);
    dec_mask_lo = tmp[31:0];
    tmp = (raw >> 20) & 'hF;
    dec_mask_hi = tmp[HI_W-1:0];
    x_dbase = 0; x_dsize = 0; x_dtype = 0; x_rep = 1'b0;
    if (on) begin
      tmp = raw & 'hFFFFFF;
      fixed = tmp;
      if (tmp != 0) begin
        h = 0;
        for (int i = 0; i < PFN_W; i++) if (((tmp >> i) & 1) == 1) h = i;
        fixed = tmp | ('hFFFFFF & ~((longint'(1) << h) - 1));
      end
      x_rep = (fixed != tmp);
      x_dsize = 'h1000000 - fixed;
      x_dbase = ((bhi & 'hF) << 20) | ((blo >> 12) & 'hFFFFF);
      x_dtype = blo & 'hFF;
    end
    x_dec = 1'b1;
  endtask

  task automatic set_srch(input longint used, input longint repl);
    slot_used = used[NSLOT-1:0]; srch_repl = repl[IDX_W:0];
    srch_valid = 1'b1;
    x_sidx = 0; x_serr = 4;
    if (repl < NSLOT) begin
      x_sidx = repl; x_serr = 0;
    end else begin
      for (int i = NSLOT - 1; i >= 0; i--) if (((used >> i) & 1) == 0) begin
        x_sidx = i; x_serr = 0;
      end
    end
    x_srch = 1'b1;
  endtask

  function automatic string enc_tag(input int err, input longint s);
    if (s == 0) return "R2";
    case (err)
      3: return "R6";
      2: return "R7";
      1: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic compare();
    chk("R1", "enc_done", longint'(enc_done), longint'(x_enc));
    chk("R1", "dec_done", longint'(dec_done), longint'(x_dec));
    chk("R1", "srch_done", longint'(srch_done), longint'(x_srch));
    if (x_enc) begin
      chk(enc_tag(x_err, x_sz), "enc_err", longint'(enc_err), longint'(x_err));
      chk(enc_tag(x_err, x_sz), "base_lo", longint'(enc_base_lo), x_blo);
      chk(enc_tag(x_err, x_sz), "base_hi", longint'(enc_base_hi), x_bhi);
      chk((x_err == 0 && x_sz != 0) ? "R4" : enc_tag(x_err, x_sz), "mask_lo", longint'(enc_mask_lo), x_mlo);
      chk((x_err == 0 && x_sz != 0) ? "R4" : enc_tag(x_err, x_sz), "mask_hi", longint'(enc_mask_hi), x_mhi);
      chk("R8", "changed", longint'(enc_changed), longint'(x_chg));
    end
    if (x_dec) begin
      chk(x_dsize == 0 ? "R9" : "R10", "dec_base", longint'(dec_base_pfn), x_dbase);
      chk(x_dsize == 0 ? "R9" : "R10", "dec_size", longint'(dec_size_pfn), x_dsize);
      chk(x_dsize == 0 ? "R9" : "R10", "dec_type", longint'(dec_type), x_dtype);
      chk("R11", "repaired", longint'(dec_repaired), longint'(x_rep));
    end
    if (x_srch) begin
      chk(srch_repl < NSLOT ? "R12" : "R13", "srch_idx", longint'(srch_idx), x_sidx);
      chk(srch_repl < NSLOT ? "R12" : "R13", "srch_err", longint'(srch_err), longint'(x_serr));
    end
  endtask

  task automatic rand_enc();
    longint s, b, t;
    int k, pick;
    k = $urandom % 14;
    s = longint'(1) << k;
    b = longint'($urandom & 'hFFFFFF) & ~(s - 1);
    pick = $urandom % 8;
    if (pick == 0) s = s + 3;
    else if (pick == 1) b = b + 1;
    else if (pick == 2) s = 0;
    else if (pick == 3) b = 'h6F000 + ($urandom % 'h2000);
    case ($urandom % 4)
      0: t = 1; 1: t = 6; 2: t = 0; default: t = $urandom % 8;
    endcase
    set_enc(b & 'hFFFFFF, s & 'hFFFFFF, t, ($urandom % 3) == 0, $urandom % 3);
  endtask

  task automatic rand_dec();
    longint raw;
    int k;
    k = $urandom % 24;
    case ($urandom % 3)
      0: raw = ('hFFFFFF << k) & 'hFFFFFF;
      1: raw = $urandom & 'hFFFFFF;
      default: raw = ($urandom & 'hFFFFFF) >> k;
    endcase
    set_dec(longint'($urandom), $urandom % 16, raw, ($urandom % 4) != 0);
  endtask

  task automatic rand_srch();
    longint u;
    u = (($urandom % 3) == 0) ? 'hFF : longint'($urandom | $urandom) & 'hFF;
    set_srch(u, $urandom % 16);
  endtask

  initial begin
    x_enc = 0; x_dec = 0; x_srch = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset enc_done", longint'(enc_done), 0);
    chk("R1", "reset dec_done", longint'(dec_done), 0);
    chk("R1", "reset srch_done", longint'(srch_done), 0);
    chk("R2", "reset mask_lo", longint'(enc_mask_lo), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      compare();
      x_enc = 0; x_dec = 0; x_srch = 0;
      enc_valid = 1'b0; dec_valid = 1'b0; srch_valid = 1'b0;
      case (cyc)
        0:  set_enc('h123, 0, 6, 0, 1);                         // R2, R8 ignored bits
        1:  begin set_enc('h100, 'h100, 6, 0, 1);                // R3 R4
                  set_dec('h12345678, 3, 'hFFF000, 0);           // R9
                  set_srch('hFF, 3); end                         // R12
        2:  begin set_enc('h100, 'h300, 0, 0, 0);                // R5 size
                  set_dec('hABCDE006, 9, 'hFFF000, 1);           // R10
                  set_srch('hF7, 12); end                        // R13
        3:  begin set_enc('h104, 'h100, 0, 0, 0);                // R5 base
                  set_dec('h00001001, 0, 'h7FF000, 1);           // R11
                  set_srch('hFF, 8); end                         // R13 full
        4:  begin set_enc('h401, 1, 0, 1, 0);                    // R6
                  set_dec('h0, 0, 0, 1); end                     // R10 zero mask
        5:  begin set_enc('h70000, 'h400, 6, 1, 0);              // R7
                  set_dec('h5000, 1, 'h800001, 1); end           // R11 no repair
        6:  set_enc('h6FC00, 'h400, 1, 1, 0);                   // R7 edge touch
        7:  set_enc('h6F800, 'h400, 1, 1, 0);                   // R7 below window
        8:  set_enc('h70400, 'h400, 6, 1, 0);                   // R7 above window
        9:  set_enc('h70000, 'h400, 0, 1, 0);                   // R7 safe type
        10: set_enc('h70000, 'h300, 0, 1, 0);                   // R5 after erratum
        11: set_enc('h70001, 1, 6, 1, 0);                       // R6 priority
        12: set_enc('hFFF000, 'h1000, 5, 0, 2);                 // R8 changed
        13: ;                                                   // R1 idle
        14: set_enc(0, 'h800000, 4, 0, 1);                      // R3 R4 largest
        default: begin
          if ($urandom % 4 != 0) rand_enc();
          if ($urandom % 4 != 0) rand_dec();
          if ($urandom % 4 != 0) rand_srch();
        end
      endcase
    end
    @(negedge clk);
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule